// File: doc/BRIEF.md
# Bit-Serial Processing Element with Virtual Slices

This block is one processing element of a wide single-instruction array. Arithmetic and logic are done one bit at a time. In each working cycle the element reads one bit of each of two operands from its own bit-addressed local memory. It forms one result bit and writes that bit straight back into the same memory. A w-bit operation therefore takes w cycles, so a 32-bit add takes 32 cycles.

A controller broadcasts an instruction made of five fields: an opcode, three base addresses (operand A, operand B, destination), the operand length and a slice-ratio exponent. The element decodes the instruction once, when it accepts it. It then replays the decoded instruction on each of the 2^v equal slices of its memory, so one physical element serves as 2^v virtual ones. When the last slice is finished, the element raises a one-cycle completion pulse.

While the element is idle, a test port can write any memory bit. The same port reads any memory bit at any time, which is how operands are loaded and results collected.

Top module: `pe_bitserial_top`

## Requirements
- R1: After reset `busy` and `done` are 0 and `issue_ready` is 1.
- R2: An instruction is taken only on a cycle where `issue_valid` and `issue_ready` are both 1. `issue_ready` is 0 for as long as `busy` is 1. An instruction offered while busy is neither queued nor executed.
- R3: Opcode 0 (add) gives, in each slice, destination = A + B mod 2^w. Operand bits are walked from bit 0 up to bit w-1. The carry is cleared at bit 0 of every slice, so no carry passes from one slice to the next.
- R4: After an add, the carry out of bit w-1 of each slice is written to the memory bit at destination + w in that slice.
- R5: Opcodes 1, 2 and 3 write the bitwise AND, OR and XOR of A and B over w bits.
- R6: Opcode 4 copies the w bits of A to the destination.
- R7: With w = `issue_len_m1`+1 and ratio 2^v, `busy` stays high for exactly 2^v*w cycles, plus 2^v cycles for an add. On the cycle after the last step `busy` is 0 and `done` is 1 for exactly one cycle.
- R8: The slice size is MEM_BITS / 2^v, with v = `issue_vp_log2`. Slice k uses each base address plus k times the slice size, and all address arithmetic wraps modulo MEM_BITS.
- R9: A test-port write presented while `busy` is 1 is ignored. When the element is idle, a test-port write stores `tst_wdata` at `tst_addr` on the clock edge. `tst_rdata` shows the bit at `tst_addr` combinationally at all times.
- R10: Opcodes 5 to 7 go through the normal step sequence, with the same timing as a logic opcode, but write nothing. For every opcode, memory bits outside the destination bits (and, for an add, outside the carry bits) are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The element can accept an instruction |
| issue_op | input | 3 | Opcode (0 add, 1 and, 2 or, 3 xor, 4 copy, 5-7 no write) |
| issue_a_base | input | ADDR_W | Base bit address of operand A |
| issue_b_base | input | ADDR_W | Base bit address of operand B |
| issue_d_base | input | ADDR_W | Base bit address of the destination |
| issue_len_m1 | input | LEN_W | Operand length minus one |
| issue_vp_log2 | input | VPL_W | Exponent of the slice ratio |
| busy | output | 1 | Steps are in progress |
| done | output | 1 | One-cycle pulse after the last step |
| tst_we | input | 1 | Test write enable (used only when idle) |
| tst_addr | input | ADDR_W | Test bit address |
| tst_wdata | input | 1 | Test write data |
| tst_rdata | output | 1 | Memory bit at `tst_addr` |

## Verification
Most internal faults show up in memory, and therefore on the test port once `done` has fired. Three examples:
- A wrong bit index or slice offset puts result bits at addresses a full readback does not expect.
- A carry that is not cleared at bit 0 corrupts the low bit of the next slice's sum.
- A decode that changes during execution gives mixed results across the slices.

Sequencing faults show up sooner. A miscounted length or slice ratio changes the number of `busy` cycles, which is visible on the very completion edge. A test write or a second issue that gets through while busy flips a bit that should have stayed put.

// File: rtl/pe_bs_pkg.sv
package pe_bs_pkg;

    localparam logic [2:0] OP_ADD  = 3'd0;
    localparam logic [2:0] OP_AND  = 3'd1;
    localparam logic [2:0] OP_OR   = 3'd2;
    localparam logic [2:0] OP_XOR  = 3'd3;
    localparam logic [2:0] OP_COPY = 3'd4;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_CARRY = 2'd2
    } pe_seq_e;

    typedef struct packed {
        logic       wr_en;
        logic       is_add;
        logic [2:0] op;
    } pe_ctrl_t;

    function automatic pe_ctrl_t decode_op(input logic [2:0] op);
        pe_ctrl_t c;
        c.op     = op;
        c.is_add = (op == OP_ADD);
        c.wr_en  = (op <= OP_COPY);
        return c;
    endfunction

    // returns {carry_out, result}
    function automatic logic [1:0] bit_alu(input logic [2:0] op, input logic a,
                                           input logic b, input logic cin);
        logic [1:0] r;
        case (op)
            OP_ADD:  r = {(a & b) | (cin & (a ^ b)), a ^ b ^ cin};
            OP_AND:  r = {1'b0, a & b};
            OP_OR:   r = {1'b0, a | b};
            OP_XOR:  r = {1'b0, a ^ b};
            default: r = {1'b0, a};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pe_bs_mem.sv
module pe_bs_mem #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    input  logic [ADDR_W-1:0] ra,
    input  logic [ADDR_W-1:0] rb,
    input  logic [ADDR_W-1:0] rt,
    output logic              da,
    output logic              db,
    output logic              dt
);
    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (we) bits_q[waddr] <= wdata;
    end

    assign da = bits_q[ra];
    assign db = bits_q[rb];
    assign dt = bits_q[rt];
endmodule

// File: rtl/pe_bs_decode.sv
module pe_bs_decode
    import pe_bs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 5,
    parameter int VPL_W  = 2,
    parameter int SL_W   = 3,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [2:0]        op_in,
    input  logic [ADDR_W-1:0] a_in,
    input  logic [ADDR_W-1:0] b_in,
    input  logic [ADDR_W-1:0] d_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [VPL_W-1:0]  vp_in,
    output pe_ctrl_t          ctrl_q,
    output logic [ADDR_W-1:0] a_q,
    output logic [ADDR_W-1:0] b_q,
    output logic [ADDR_W-1:0] d_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [SH_W-1:0]   shamt_q,
    output logic [SL_W-1:0]   last_slice_q
);
    logic [SL_W:0]   nslice_m1;
    logic [SH_W-1:0] shamt;

    always_comb begin
        nslice_m1 = ((SL_W+1)'(1) << vp_in) - (SL_W+1)'(1);
        shamt     = SH_W'(ADDR_W) - SH_W'(vp_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            a_q          <= '0;
            b_q          <= '0;
            d_q          <= '0;
            len_q        <= '0;
            shamt_q      <= '0;
            last_slice_q <= '0;
        end else if (load) begin
            ctrl_q       <= decode_op(op_in);
            a_q          <= a_in;
            b_q          <= b_in;
            d_q          <= d_in;
            len_q        <= len_in;
            shamt_q      <= shamt;
            last_slice_q <= nslice_m1[SL_W-1:0];
        end
    end
endmodule

// File: rtl/pe_bs_seq.sv
module pe_bs_seq
    import pe_bs_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int SL_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [SL_W-1:0]  last_slice,
    input  logic             carry_en,
    output logic             busy,
    output logic             done,
    output logic             carry_phase,
    output logic [LEN_W-1:0] bit_idx,
    output logic [SL_W-1:0]  slice_idx
);
    pe_seq_e state_q;

    assign busy        = (state_q != SQ_IDLE);
    assign carry_phase = (state_q == SQ_CARRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            bit_idx   <= '0;
            slice_idx <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q   <= SQ_RUN;
                        bit_idx   <= '0;
                        slice_idx <= '0;
                    end
                end
                SQ_RUN: begin
                    if (bit_idx != len_m1) begin
                        bit_idx <= bit_idx + LEN_W'(1);
                    end else if (carry_en) begin
                        state_q <= SQ_CARRY;
                    end else if (slice_idx == last_slice) begin
                        state_q <= SQ_IDLE;
                        done    <= 1'b1;
                    end else begin
                        slice_idx <= slice_idx + SL_W'(1);
                        bit_idx   <= '0;
                    end
                end
                SQ_CARRY: begin
                    if (slice_idx == last_slice) begin
                        state_q <= SQ_IDLE;
                        done    <= 1'b1;
                    end else begin
                        state_q   <= SQ_RUN;
                        slice_idx <= slice_idx + SL_W'(1);
                        bit_idx   <= '0;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pe_bitserial_top.sv
module pe_bitserial_top
    import pe_bs_pkg::*;
#(
    parameter int MEM_BITS    = 256,
    parameter int MAX_LEN     = 32,
    parameter int MAX_VP_LOG2 = 3,
    localparam int ADDR_W = $clog2(MEM_BITS),
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int VPL_W  = (MAX_VP_LOG2 > 0) ? $clog2(MAX_VP_LOG2 + 1) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [2:0]        issue_op,
    input  logic [ADDR_W-1:0] issue_a_base,
    input  logic [ADDR_W-1:0] issue_b_base,
    input  logic [ADDR_W-1:0] issue_d_base,
    input  logic [LEN_W-1:0]  issue_len_m1,
    input  logic [VPL_W-1:0]  issue_vp_log2,
    output logic              busy,
    output logic              done,
    input  logic              tst_we,
    input  logic [ADDR_W-1:0] tst_addr,
    input  logic              tst_wdata,
    output logic              tst_rdata
);
    localparam int SL_W = (MAX_VP_LOG2 > 0) ? MAX_VP_LOG2 : 1;
    localparam int SH_W = $clog2(ADDR_W + 1);

    pe_ctrl_t          ctrl_q;
    logic [ADDR_W-1:0] a_q, b_q, d_q;
    logic [LEN_W-1:0]  len_q;
    logic [SH_W-1:0]   shamt_q;
    logic [SL_W-1:0]   last_slice_q;

    logic              accept;
    logic              carry_phase;
    logic [LEN_W-1:0]  bit_idx;
    logic [SL_W-1:0]   slice_idx;
    logic              carry_q;
    logic              cin;
    logic [1:0]        alu_out;
    logic [ADDR_W-1:0] slice_off, step, addr_a, addr_b, addr_d;
    logic              bit_a, bit_b;
    logic              mem_we, mem_wd;
    logic [ADDR_W-1:0] mem_wa;

    assign issue_ready = ~busy;
    assign accept      = issue_valid & ~busy;

    pe_bs_decode #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .VPL_W(VPL_W), .SL_W(SL_W), .SH_W(SH_W)
    ) dec_i (
        .clk(clk), .rst(rst), .load(accept),
        .op_in(issue_op), .a_in(issue_a_base), .b_in(issue_b_base),
        .d_in(issue_d_base), .len_in(issue_len_m1), .vp_in(issue_vp_log2),
        .ctrl_q(ctrl_q), .a_q(a_q), .b_q(b_q), .d_q(d_q), .len_q(len_q),
        .shamt_q(shamt_q), .last_slice_q(last_slice_q)
    );

    pe_bs_seq #(.LEN_W(LEN_W), .SL_W(SL_W)) seq_i (
        .clk(clk), .rst(rst), .start(accept),
        .len_m1(len_q), .last_slice(last_slice_q), .carry_en(ctrl_q.is_add),
        .busy(busy), .done(done), .carry_phase(carry_phase),
        .bit_idx(bit_idx), .slice_idx(slice_idx)
    );

    always_comb begin
        slice_off = ADDR_W'(slice_idx) << shamt_q;
        step      = slice_off + ADDR_W'(bit_idx);
        addr_a    = a_q + step;
        addr_b    = b_q + step;
        addr_d    = d_q + step + (carry_phase ? ADDR_W'(1) : ADDR_W'(0));
        cin       = (bit_idx == '0) ? 1'b0 : carry_q;
        alu_out   = bit_alu(ctrl_q.op, bit_a, bit_b, cin);
        if (busy) begin
            mem_we = carry_phase | ctrl_q.wr_en;
            mem_wa = addr_d;
            mem_wd = carry_phase ? carry_q : alu_out[0];
        end else begin
            mem_we = tst_we;
            mem_wa = tst_addr;
            mem_wd = tst_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else if (busy && !carry_phase && ctrl_q.is_add) begin
            carry_q <= alu_out[1];
        end
    end

    pe_bs_mem #(.DEPTH(MEM_BITS), .ADDR_W(ADDR_W)) mem_i (
        .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
        .ra(addr_a), .rb(addr_b), .rt(tst_addr),
        .da(bit_a), .db(bit_b), .dt(tst_rdata)
    );
endmodule

// File: rtl/pe_bs_chk.sv
module pe_bs_chk
    import pe_bs_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_ready,
    input logic             busy,
    input logic             done,
    input logic             carry_phase,
    input pe_ctrl_t         ctrl,
    input logic [LEN_W-1:0] len_m1,
    input logic [LEN_W-1:0] bit_idx
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));

    a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !issue_ready);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r4_carry_only_add: assert property (@(posedge clk) disable iff (rst)
        carry_phase |-> ctrl.is_add);

    a_r8_decode_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ctrl) && $stable(len_m1)));

    a_r3_bit_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx <= len_m1));
endmodule

bind pe_bitserial_top pe_bs_chk #(.LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst(rst), .issue_ready(issue_ready), .busy(busy), .done(done),
    .carry_phase(carry_phase), .ctrl(ctrl_q), .len_m1(len_q), .bit_idx(bit_idx)
);

// File: tb/pe_bitserial_top_tb.sv
module pe_bitserial_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM        = 256;
    localparam int MAXV       = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue_valid = 1'b0;
    logic       issue_ready;
    logic [2:0] issue_op = '0;
    logic [7:0] issue_a_base = '0, issue_b_base = '0, issue_d_base = '0;
    logic [4:0] issue_len_m1 = '0;
    logic [1:0] issue_vp_log2 = '0;
    logic       busy, done;
    logic       tst_we = 1'b0;
    logic [7:0] tst_addr = '0;
    logic       tst_wdata = 1'b0;
    logic       tst_rdata;

    logic [MEM-1:0] mm;
    logic [31:0]    seed = 32'h1234_5678;
    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_bitserial_top dut_i (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_op(issue_op), .issue_a_base(issue_a_base), .issue_b_base(issue_b_base),
        .issue_d_base(issue_d_base), .issue_len_m1(issue_len_m1),
        .issue_vp_log2(issue_vp_log2), .busy(busy), .done(done),
        .tst_we(tst_we), .tst_addr(tst_addr), .tst_wdata(tst_wdata), .tst_rdata(tst_rdata)
    );

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < MEM; i++) begin
            seed = xs(seed);
            mm[i] = seed[7];
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < MEM; i++) begin
            @(negedge clk);
            tst_we = 1'b1; tst_addr = 8'(i); tst_wdata = mm[i];
        end
        @(negedge clk);
        tst_we = 1'b0;
    endtask

    task automatic check_mem(input string tag);
        int mism = 0;
        int first = -1;
        for (int i = 0; i < MEM; i++) begin
            tst_addr = 8'(i);
            #1;
            if (tst_rdata !== mm[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        if (mism != 0)
            $display("  first mismatch at bit %0d, model %0b", first, mm[first]);
        chk(mism == 0, tag, "memory mismatch bits", mism, 0);
    endtask

    // reference: arithmetic per slice, no overlap between regions
    task automatic model_op(input int op, input int a, input int b, input int d,
                            input int len, input int vp);
        int sz = MEM >> vp;
        for (int k = 0; k < (1 << vp); k++) begin
            logic [32:0] av = '0, bv = '0, rv = '0;
            int off = k * sz;
            for (int j = 0; j < len; j++) begin
                av[j] = mm[(a + off + j) % MEM];
                bv[j] = mm[(b + off + j) % MEM];
            end
            case (op)
                0: rv = av + bv;
                1: rv = av & bv;
                2: rv = av | bv;
                3: rv = av ^ bv;
                4: rv = av;
                default: rv = '0;
            endcase
            if (op <= 4)
                for (int j = 0; j < len; j++) mm[(d + off + j) % MEM] = rv[j];
            if (op == 0) mm[(d + off + len) % MEM] = rv[len];
        end
    endtask

    task automatic run_op(input int op, input int a, input int b, input int d,
                          input int len, input int vp, input string tag);
        int cnt = 0;
        int expc = (1 << vp) * (len + ((op == 0) ? 1 : 0));
        @(negedge clk);
        chk(issue_ready == 1'b1, "R2", "ready before issue", issue_ready, 1);
        issue_valid = 1'b1; issue_op = 3'(op);
        issue_a_base = 8'(a); issue_b_base = 8'(b); issue_d_base = 8'(d);
        issue_len_m1 = 5'(len - 1); issue_vp_log2 = 2'(vp);
        @(negedge clk);
        issue_valid = 1'b0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == expc, "R7", "busy cycles", cnt, expc);
        chk(done == 1'b1, "R7", "done after last step", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done single pulse", done, 0);
        model_op(op, a, b, d, len, vp);
        check_mem(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(issue_ready == 1'b1, "R1", "ready after reset", issue_ready, 1);

        // R9 idle test write / read path
        fill_random();
        load_all();
        check_mem("R9");

        // sweep: R3 R5 R6 R8 R10 over every opcode, slice ratio, and length class
        for (int op = 0; op < 8; op++) begin
            for (int vp = 0; vp <= MAXV; vp++) begin
                for (int li = 0; li < 3; li++) begin
                    int sz = MEM >> vp;
                    int lmax = (sz / 4 - 1 > 32) ? 32 : sz / 4 - 1;
                    int len = (li == 0) ? 1 : ((li == 1) ? 5 : lmax);
                    string tag;
                    case (op)
                        0: tag = "R3";
                        1, 2, 3: tag = "R5";
                        4: tag = "R6";
                        default: tag = "R10";
                    endcase
                    if (vp != 0) tag = {tag, "/R8"};
                    fill_random();
                    load_all();
                    run_op(op, 1, sz / 4 + 1, sz / 2 + 1, len, vp, tag);
                end
            end
        end

        // R3 R4: carry chain into carry bit, carry cleared between slices
        fill_random();
        for (int j = 0; j < 8; j++) begin
            mm[j] = 1'b1;          mm[32 + j] = (j == 0);
            mm[128 + j] = 1'b0;    mm[160 + j] = 1'b0;
        end
        load_all();
        run_op(0, 0, 32, 64, 8, 1, "R4");
        tst_addr = 8'd72; #1;
        chk(tst_rdata == 1'b1, "R4", "slice0 carry bit", tst_rdata, 1);
        tst_addr = 8'd200; #1;
        chk(tst_rdata == 1'b0, "R3", "slice1 carry not inherited", tst_rdata, 0);
        tst_addr = 8'd192; #1;
        chk(tst_rdata == 1'b0, "R3", "slice1 sum bit0 clear carry", tst_rdata, 0);

        // R2 R9: issue and test write while busy are ignored
        fill_random();
        load_all();
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 3'd1;
        issue_a_base = 8'd0; issue_b_base = 8'd64; issue_d_base = 8'd128;
        issue_len_m1 = 5'd7; issue_vp_log2 = 2'd0;
        @(negedge clk);
        chk(issue_ready == 1'b0, "R2", "ready while busy", issue_ready, 0);
        issue_op = 3'd4; issue_d_base = 8'd20;
        tst_we = 1'b1; tst_addr = 8'd20; tst_wdata = ~mm[20];
        @(negedge clk);
        issue_valid = 1'b0; tst_we = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R2", "busy-time issue not queued", busy, 0);
        model_op(1, 0, 64, 128, 8, 0);
        check_mem("R9");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule